// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

A register-mapped interrupt controller that gathers 64 level-sensitive request lines and presents them to a processor on two request outputs: a normal request and a fast request. Every source carries its own enable bit, a routing bit that selects the normal or the fast path, and a 4-bit priority. Software can also raise any source by setting its force bit. Pending sources of each path can be read back, and a vector/status word per path names the source that should be serviced next.

Software talks to the block over a simple 32-bit bus. It has an address, a write strobe and write data. Read data is driven combinationally from the address. Enables can be changed one source at a time by writing a source number to a set-number or clear-number register. This leaves every other enable bit alone and needs no read-modify-write. A global level mask holds back normal requests whose priority is too low. The request outputs and both vector words are registered, so they follow a change at the inputs one clock later.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset the control register reads 0, the level mask reads 0x1F, all enable, routing, force and priority bits are 0, both vector words read 0xFFFFFFFF and both request outputs are low.
- R2: Writing a value N below 64 to the set-number register (0x08) sets enable bit N and changes no other enable bit.
- R3: Writing a value N below 64 to the clear-number register (0x0C) clears enable bit N and changes no other enable bit.
- R4: Writing a value of 64 or more (compared over all 32 bits) to 0x08 or 0x0C leaves every enable bit unchanged.
- R5: Source N below 32 sits at bit N of the low word of each per-source register pair: enable 0x14, routing 0x1C, raw 0x4C, force 0x54, normal pending 0x5C, fast pending 0x64. Source N from 32 up sits at bit N-32 of the high word at the address 4 lower.
- R6: A source is pending when (raw input OR force bit) AND its enable bit is 1. Pending reads follow the inputs in the same cycle. A routing bit of 0 places the source in normal pending and a routing bit of 1 places it in fast pending.
- R7: The priority of source N is bits [4*(N%8)+3 : 4*(N%8)] of priority word k = N/8, and word k sits at address 0x20 + 4*(7-k).
- R8: The normal vector word (0x40) holds the source number of the highest-priority normal-pending source in bits [31:16] and its priority in bits [15:0]. When priorities are equal the higher source number wins. The word reads 0xFFFFFFFF when no normal source is pending. The level mask does not affect this word.
- R9: The normal request is high exactly when a normal-pending source has a priority that passes the level mask (0x04, 5 bits). A priority passes when bit 4 of the mask is 1, or when the priority is greater than the mask value.
- R10: The fast vector word (0x44) holds the highest-numbered fast-pending source, or 0xFFFFFFFF when none is pending. The fast request is high exactly when any source is fast pending.
- R11: Both request outputs and both vector words are registered. They take their new value on the first rising clock edge after the cause changes.
- R12: Writes to the vector words, the raw words and the pending words have no effect on any readable state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| src_in | input | 64 | Level-sensitive raw request lines |
| irq_norm | output | 1 | Registered normal interrupt request |
| irq_fast | output | 1 | Registered fast interrupt request |

## Verification
The bench builds the block with its package defaults: 64 sources, 4-bit priorities and eight priority words. This places every word pair and both ends of the reversed priority-word order within reach, including source 63 in the lowest-addressed word and source 0 in the highest. With this full width, one sweep can set and clear every source number through the number registers, and the out-of-range values 64, 71 and 0x10003 can be checked for having no effect. These out-of-range values alias a real bit in their low six bits. Priority ties across the low and high halves, mask values around the winning priority, and the mask's pass-all bit are driven against hand-worked vector and request values.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam int NUM_SRC   = 64;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 8;
  localparam int HALF      = NUM_SRC / 2;
  localparam int PRIO_W    = 4;
  localparam int MASK_W    = PRIO_W + 1;
  localparam int IDX_W     = $clog2(NUM_SRC);
  localparam int PER_WORD  = DATA_W / PRIO_W;
  localparam int NUM_PWORD = NUM_SRC / PER_WORD;
  localparam int VF_W      = DATA_W / 2;

  typedef logic [ADDR_W-1:0] addr_t;

  localparam logic [DATA_W-1:0] VEC_NONE = '1;
  localparam logic [MASK_W-1:0] MASK_RST = '1;

  localparam addr_t A_CTRL      = 8'h00;
  localparam addr_t A_LVLMSK    = 8'h04;
  localparam addr_t A_ENSET     = 8'h08;
  localparam addr_t A_ENCLR     = 8'h0C;
  localparam addr_t A_EN_HI     = 8'h10;
  localparam addr_t A_EN_LO     = 8'h14;
  localparam addr_t A_TY_HI     = 8'h18;
  localparam addr_t A_TY_LO     = 8'h1C;
  localparam addr_t A_PRIO_BASE = 8'h20;
  localparam addr_t A_NVEC      = 8'h40;
  localparam addr_t A_FVEC      = 8'h44;
  localparam addr_t A_RAW_HI    = 8'h48;
  localparam addr_t A_RAW_LO    = 8'h4C;
  localparam addr_t A_FRC_HI    = 8'h50;
  localparam addr_t A_FRC_LO    = 8'h54;
  localparam addr_t A_NP_HI     = 8'h58;
  localparam addr_t A_NP_LO     = 8'h5C;
  localparam addr_t A_FP_HI     = 8'h60;
  localparam addr_t A_FP_LO     = 8'h64;

  // Priority word k lives at a reversed address: the last word comes first.
  function automatic addr_t prio_addr(int k);
    return addr_t'(int'(A_PRIO_BASE) + 4 * (NUM_PWORD - 1 - k));
  endfunction

  // A priority passes the level mask when the mask's top bit is set
  // or the priority exceeds the mask value.
  function automatic logic mask_pass(logic [PRIO_W-1:0] p, logic [MASK_W-1:0] m);
    return m[MASK_W-1] | (MASK_W'(p) > m);
  endfunction

  function automatic logic [DATA_W-1:0] pack_vec(logic [IDX_W-1:0] idx,
                                                 logic [PRIO_W-1:0] p);
    return {VF_W'(idx), VF_W'(p)};
  endfunction

  function automatic logic num_ok(logic [DATA_W-1:0] d);
    return d < DATA_W'(NUM_SRC);
  endfunction
endpackage

// File: rtl/ivc_regfile.sv
module ivc_regfile
  import ivc_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  addr_t                      wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  output logic [NUM_SRC-1:0]         en_q,
  output logic [NUM_SRC-1:0]         type_q,
  output logic [NUM_SRC-1:0]         frc_q,
  output logic [PRIO_W*NUM_SRC-1:0]  prio_flat,
  output logic [DATA_W-1:0]          ctrl_q,
  output logic [MASK_W-1:0]          lvl_mask_q,
  output logic                       num_set_hit,
  output logic                       num_clr_hit,
  output logic                       num_reject
);
  logic [DATA_W-1:0]  pword_q [NUM_PWORD];
  logic [NUM_SRC-1:0] en_d;
  logic [IDX_W-1:0]   num_idx;
  logic               num_wr;

  assign num_idx     = wr_data[IDX_W-1:0];
  assign num_wr      = wr_en && (wr_addr == A_ENSET || wr_addr == A_ENCLR);
  assign num_set_hit = wr_en && (wr_addr == A_ENSET) && num_ok(wr_data);
  assign num_clr_hit = wr_en && (wr_addr == A_ENCLR) && num_ok(wr_data);
  assign num_reject  = num_wr && !num_ok(wr_data);

  // R2 R3 R4: atomic single-bit updates beside the full-word writes
  always_comb begin
    en_d = en_q;
    if (wr_en && wr_addr == A_EN_LO) en_d[HALF-1:0]       = wr_data;
    if (wr_en && wr_addr == A_EN_HI) en_d[NUM_SRC-1:HALF] = wr_data;
    if (num_set_hit) en_d[num_idx] = 1'b1;
    if (num_clr_hit) en_d[num_idx] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= '0;
      type_q     <= '0;
      frc_q      <= '0;
      ctrl_q     <= '0;
      lvl_mask_q <= MASK_RST;
    end else begin
      en_q <= en_d;
      if (wr_en) begin
        case (wr_addr)
          A_CTRL:   ctrl_q                  <= wr_data;
          A_LVLMSK: lvl_mask_q              <= wr_data[MASK_W-1:0];
          A_TY_LO:  type_q[HALF-1:0]        <= wr_data;
          A_TY_HI:  type_q[NUM_SRC-1:HALF]  <= wr_data;
          A_FRC_LO: frc_q[HALF-1:0]         <= wr_data;
          A_FRC_HI: frc_q[NUM_SRC-1:HALF]   <= wr_data;
          default: ;
        endcase
      end
    end
  end

  // R7: priority words, reversed address order
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_PWORD; k++) pword_q[k] <= '0;
    end else begin
      for (int k = 0; k < NUM_PWORD; k++)
        if (wr_en && wr_addr == prio_addr(k)) pword_q[k] <= wr_data;
    end
  end

  for (genvar k = 0; k < NUM_PWORD; k++) begin : g_pflat
    assign prio_flat[k*DATA_W +: DATA_W] = pword_q[k];
  end
endmodule

// File: rtl/ivc_select.sv
module ivc_select
  import ivc_pkg::*;
(
  input  logic [NUM_SRC-1:0]        n_pend,
  input  logic [NUM_SRC-1:0]        f_pend,
  input  logic [PRIO_W*NUM_SRC-1:0] prio_flat,
  input  logic [MASK_W-1:0]         lvl_mask,
  output logic [DATA_W-1:0]         n_vec_d,
  output logic [DATA_W-1:0]         f_vec_d,
  output logic                      n_req_d,
  output logic                      f_req_d
);
  logic [PRIO_W-1:0] prio_a [NUM_SRC];
  logic              n_found;
  logic [IDX_W-1:0]  n_idx;
  logic [PRIO_W-1:0] n_pr;
  logic              f_found;
  logic [IDX_W-1:0]  f_idx;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_unpack
    assign prio_a[g] = prio_flat[g*PRIO_W +: PRIO_W];
  end

  // R8: ascending scan with >= so equal priority goes to the higher number
  always_comb begin
    n_found = 1'b0;
    n_idx   = '0;
    n_pr    = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (n_pend[i] && (!n_found || prio_a[i] >= n_pr)) begin
        n_found = 1'b1;
        n_idx   = IDX_W'(i);
        n_pr    = prio_a[i];
      end
    end
  end

  // R10: last pending source in ascending order is the highest-numbered one
  always_comb begin
    f_found = 1'b0;
    f_idx   = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (f_pend[i]) begin
        f_found = 1'b1;
        f_idx   = IDX_W'(i);
      end
    end
  end

  assign n_vec_d = n_found ? pack_vec(n_idx, n_pr) : VEC_NONE;
  assign f_vec_d = f_found ? DATA_W'(f_idx) : VEC_NONE;
  // R9: the winner carries the largest priority, so it alone decides the mask
  assign n_req_d = n_found && mask_pass(n_pr, lvl_mask);
  assign f_req_d = f_found;
endmodule

// File: rtl/ivc_readmux.sv
module ivc_readmux
  import ivc_pkg::*;
(
  input  addr_t                     rd_addr,
  input  logic [DATA_W-1:0]         ctrl_q,
  input  logic [MASK_W-1:0]         lvl_mask_q,
  input  logic [NUM_SRC-1:0]        en_q,
  input  logic [NUM_SRC-1:0]        type_q,
  input  logic [NUM_SRC-1:0]        frc_q,
  input  logic [NUM_SRC-1:0]        raw_in,
  input  logic [NUM_SRC-1:0]        n_pend,
  input  logic [NUM_SRC-1:0]        f_pend,
  input  logic [PRIO_W*NUM_SRC-1:0] prio_flat,
  input  logic [DATA_W-1:0]         n_vec_q,
  input  logic [DATA_W-1:0]         f_vec_q,
  output logic [DATA_W-1:0]         rd_data
);
  logic [DATA_W-1:0] prio_rd;

  always_comb begin
    prio_rd = '0;
    for (int k = 0; k < NUM_PWORD; k++)
      if (rd_addr == prio_addr(k)) prio_rd = prio_flat[k*DATA_W +: DATA_W];
  end

  // R5: high words hold sources HALF..NUM_SRC-1
  always_comb begin
    case (rd_addr)
      A_CTRL:   rd_data = ctrl_q;
      A_LVLMSK: rd_data = DATA_W'(lvl_mask_q);
      A_ENSET:  rd_data = '0;
      A_ENCLR:  rd_data = '0;
      A_EN_HI:  rd_data = en_q[NUM_SRC-1:HALF];
      A_EN_LO:  rd_data = en_q[HALF-1:0];
      A_TY_HI:  rd_data = type_q[NUM_SRC-1:HALF];
      A_TY_LO:  rd_data = type_q[HALF-1:0];
      A_NVEC:   rd_data = n_vec_q;
      A_FVEC:   rd_data = f_vec_q;
      A_RAW_HI: rd_data = raw_in[NUM_SRC-1:HALF];
      A_RAW_LO: rd_data = raw_in[HALF-1:0];
      A_FRC_HI: rd_data = frc_q[NUM_SRC-1:HALF];
      A_FRC_LO: rd_data = frc_q[HALF-1:0];
      A_NP_HI:  rd_data = n_pend[NUM_SRC-1:HALF];
      A_NP_LO:  rd_data = n_pend[HALF-1:0];
      A_FP_HI:  rd_data = f_pend[NUM_SRC-1:HALF];
      A_FP_LO:  rd_data = f_pend[HALF-1:0];
      default:  rd_data = prio_rd;
    endcase
  end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import ivc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_we,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [NUM_SRC-1:0]   src_in,
  output logic                 irq_norm,
  output logic                 irq_fast
);
  logic [NUM_SRC-1:0]        en_q;
  logic [NUM_SRC-1:0]        type_q;
  logic [NUM_SRC-1:0]        frc_q;
  logic [PRIO_W*NUM_SRC-1:0] prio_flat;
  logic [DATA_W-1:0]         ctrl_q;
  logic [MASK_W-1:0]         lvl_mask_q;
  logic                      num_set_hit;
  logic                      num_clr_hit;
  logic                      num_reject;
  logic [NUM_SRC-1:0]        req_any;
  logic [NUM_SRC-1:0]        n_pend;
  logic [NUM_SRC-1:0]        f_pend;
  logic [DATA_W-1:0]         n_vec_d;
  logic [DATA_W-1:0]         f_vec_d;
  logic                      n_req_d;
  logic                      f_req_d;
  logic [DATA_W-1:0]         n_vec_q;
  logic [DATA_W-1:0]         f_vec_q;
  logic                      irq_n_q;
  logic                      irq_f_q;

  ivc_regfile u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (bus_we),
    .wr_addr     (bus_addr),
    .wr_data     (bus_wdata),
    .en_q        (en_q),
    .type_q      (type_q),
    .frc_q       (frc_q),
    .prio_flat   (prio_flat),
    .ctrl_q      (ctrl_q),
    .lvl_mask_q  (lvl_mask_q),
    .num_set_hit (num_set_hit),
    .num_clr_hit (num_clr_hit),
    .num_reject  (num_reject)
  );

  // R6: level-sensitive, unlatched pending
  assign req_any = (src_in | frc_q) & en_q;
  assign n_pend  = req_any & ~type_q;
  assign f_pend  = req_any & type_q;

  ivc_select u_sel (
    .n_pend    (n_pend),
    .f_pend    (f_pend),
    .prio_flat (prio_flat),
    .lvl_mask  (lvl_mask_q),
    .n_vec_d   (n_vec_d),
    .f_vec_d   (f_vec_d),
    .n_req_d   (n_req_d),
    .f_req_d   (f_req_d)
  );

  // R11: one register stage on every output of the selector
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_vec_q <= VEC_NONE;
      f_vec_q <= VEC_NONE;
      irq_n_q <= 1'b0;
      irq_f_q <= 1'b0;
    end else begin
      n_vec_q <= n_vec_d;
      f_vec_q <= f_vec_d;
      irq_n_q <= n_req_d;
      irq_f_q <= f_req_d;
    end
  end

  assign irq_norm = irq_n_q;
  assign irq_fast = irq_f_q;

  ivc_readmux u_rd (
    .rd_addr    (bus_addr),
    .ctrl_q     (ctrl_q),
    .lvl_mask_q (lvl_mask_q),
    .en_q       (en_q),
    .type_q     (type_q),
    .frc_q      (frc_q),
    .raw_in     (src_in),
    .n_pend     (n_pend),
    .f_pend     (f_pend),
    .prio_flat  (prio_flat),
    .n_vec_q    (n_vec_q),
    .f_vec_q    (f_vec_q),
    .rd_data    (bus_rdata)
  );
endmodule

// File: rtl/ivc_chk.sv
module ivc_chk
  import ivc_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic [NUM_SRC-1:0] en_vec,
  input logic               set_hit,
  input logic               clr_hit,
  input logic               reject,
  input logic               irq_n,
  input logic               irq_f,
  input logic [DATA_W-1:0]  n_vec,
  input logic [DATA_W-1:0]  f_vec
);
  // R2
  en_set_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_hit |=> en_vec[$past(bus_wdata[IDX_W-1:0])]);

  // R3
  en_clr_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit |=> !en_vec[$past(bus_wdata[IDX_W-1:0])]);

  // R2 R3: a number write touches at most one enable bit
  en_single_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_hit || clr_hit) |=> ($countones(en_vec ^ $past(en_vec)) <= 1));

  // R4
  en_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> $stable(en_vec));

  // R9
  norm_req_has_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_n |-> (n_vec != VEC_NONE));

  // R8
  norm_vec_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (n_vec != VEC_NONE) |-> (n_vec[VF_W-1:PRIO_W] == '0 &&
                             n_vec[DATA_W-1:VF_W] < VF_W'(NUM_SRC)));

  // R10
  fast_req_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_f == (f_vec != VEC_NONE));
endmodule

bind irq_vec_ctrl ivc_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wdata (bus_wdata),
  .en_vec    (en_q),
  .set_hit   (num_set_hit),
  .clr_hit   (num_clr_hit),
  .reject    (num_reject),
  .irq_n     (irq_norm),
  .irq_f     (irq_fast),
  .n_vec     (n_vec_q),
  .f_vec     (f_vec_q)
);

// File: tb/irq_vec_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_vec_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [63:0] src_in;
  logic        irq_norm;
  logic        irq_fast;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  irq_vec_ctrl dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .src_in    (src_in),
    .irq_norm  (irq_norm),
    .irq_fast  (irq_fast)
  );

  localparam logic [2:0] K_WR  = 3'd0;
  localparam logic [2:0] K_RD  = 3'd1;
  localparam logic [2:0] K_RLO = 3'd2;
  localparam logic [2:0] K_RHI = 3'd3;
  localparam logic [2:0] K_PIN = 3'd4;
  localparam int NV = 63;

  // {requirement, kind, address, data}; pin checks compare {irq_fast, irq_norm}
  localparam logic [46:0] VT [NV] = '{
    {4'd1,  K_RD,  8'h14, 32'h0},          // R1 enables low
    {4'd1,  K_RD,  8'h04, 32'h1F},         // R1 mask
    {4'd1,  K_RD,  8'h40, 32'hFFFFFFFF},   // R1 normal vector
    {4'd1,  K_RD,  8'h44, 32'hFFFFFFFF},   // R1 fast vector
    {4'd1,  K_RD,  8'h00, 32'h0},          // R1 control
    {4'd1,  K_RD,  8'h3C, 32'h0},          // R1 priority word
    {4'd1,  K_PIN, 8'h00, 32'h0},          // R1 requests low
    {4'd2,  K_WR,  8'h08, 32'd5},
    {4'd2,  K_RD,  8'h14, 32'h20},         // R2
    {4'd5,  K_WR,  8'h08, 32'd40},
    {4'd5,  K_RD,  8'h10, 32'h100},        // R5 source 40 -> high bit 8
    {4'd5,  K_RD,  8'h14, 32'h20},         // R5
    {4'd4,  K_WR,  8'h08, 32'd64},
    {4'd4,  K_RD,  8'h14, 32'h20},         // R4 value 64
    {4'd4,  K_RD,  8'h10, 32'h100},        // R4
    {4'd4,  K_WR,  8'h08, 32'h00010003},
    {4'd4,  K_RD,  8'h14, 32'h20},         // R4 large value, low bits alias 3
    {4'd2,  K_WR,  8'h08, 32'd7},
    {4'd2,  K_RD,  8'h14, 32'hA0},         // R2
    {4'd3,  K_WR,  8'h0C, 32'd5},
    {4'd3,  K_RD,  8'h14, 32'h80},         // R3
    {4'd4,  K_WR,  8'h0C, 32'd71},
    {4'd4,  K_RD,  8'h14, 32'h80},         // R4 value 71 aliases 7
    {4'd6,  K_RLO, 8'h00, 32'h80},
    {4'd6,  K_RD,  8'h5C, 32'h80},         // R6
    {4'd8,  K_RD,  8'h40, 32'h00070000},   // R8
    {4'd9,  K_PIN, 8'h00, 32'h1},          // R9 mask pass-all
    {4'd7,  K_WR,  8'h28, 32'h9},
    {4'd7,  K_RD,  8'h40, 32'h00070000},   // R7 source 40 not yet pending
    {4'd6,  K_RHI, 8'h00, 32'h100},
    {4'd6,  K_RD,  8'h58, 32'h100},        // R6
    {4'd7,  K_RD,  8'h40, 32'h00280009},   // R7
    {4'd8,  K_WR,  8'h3C, 32'h90000000},
    {4'd8,  K_RD,  8'h40, 32'h00280009},   // R8 tie -> higher number
    {4'd8,  K_WR,  8'h3C, 32'hA0000000},
    {4'd8,  K_RD,  8'h40, 32'h0007000A},   // R8
    {4'd9,  K_WR,  8'h04, 32'd10},
    {4'd9,  K_PIN, 8'h00, 32'h0},          // R9 10 not above 10
    {4'd8,  K_RD,  8'h40, 32'h0007000A},   // R8 mask does not touch vector
    {4'd9,  K_WR,  8'h04, 32'd9},
    {4'd9,  K_PIN, 8'h00, 32'h1},          // R9
    {4'd9,  K_WR,  8'h04, 32'h0F},
    {4'd9,  K_PIN, 8'h00, 32'h0},          // R9
    {4'd9,  K_WR,  8'h04, 32'h10},
    {4'd9,  K_PIN, 8'h00, 32'h1},          // R9 top mask bit
    {4'd10, K_WR,  8'h1C, 32'h80},
    {4'd6,  K_RD,  8'h5C, 32'h0},          // R6
    {4'd10, K_RD,  8'h64, 32'h80},         // R10
    {4'd10, K_RD,  8'h44, 32'h7},          // R10
    {4'd10, K_PIN, 8'h00, 32'h3},          // R10
    {4'd10, K_WR,  8'h18, 32'h100},
    {4'd10, K_RD,  8'h44, 32'h28},         // R10 highest number
    {4'd8,  K_RD,  8'h40, 32'hFFFFFFFF},   // R8 none
    {4'd6,  K_WR,  8'h54, 32'h2},
    {4'd6,  K_RD,  8'h5C, 32'h0},          // R6 force without enable
    {4'd6,  K_WR,  8'h08, 32'd1},
    {4'd6,  K_RD,  8'h5C, 32'h2},          // R6 force
    {4'd9,  K_WR,  8'h04, 32'h0},
    {4'd9,  K_PIN, 8'h00, 32'h2},          // R9 priority 0 blocked by mask 0
    {4'd12, K_WR,  8'h40, 32'h12345678},
    {4'd12, K_RD,  8'h40, 32'h00010000},   // R12
    {4'd12, K_WR,  8'h5C, 32'h0},
    {4'd12, K_RD,  8'h5C, 32'h2}           // R12
  };

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic rd(input int req, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    check(req, bus_rdata, exp);
  endtask

  task automatic pins(input int req, input logic [1:0] exp);
    @(posedge clk);
    @(negedge clk);
    check(req, {30'b0, irq_fast, irq_norm}, {30'b0, exp});
  endtask

  logic [63:0] model;
  logic [3:0]  t_req;
  logic [2:0]  t_kind;
  logic [7:0]  t_addr;
  logic [31:0] t_data;

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; src_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      {t_req, t_kind, t_addr, t_data} = VT[i];
      case (t_kind)
        K_WR:    wr(t_addr, t_data);
        K_RD:    rd(int'(t_req), t_addr, t_data);
        K_RLO:   begin @(negedge clk); src_in[31:0]  = t_data; end
        K_RHI:   begin @(negedge clk); src_in[63:32] = t_data; end
        default: pins(int'(t_req), t_data[1:0]);
      endcase
    end
    rd(12, 8'h4C, 32'h80);   // R12 raw reads the input after the earlier table writes
    wr(8'h4C, 32'h0);
    rd(12, 8'h4C, 32'h80);   // R12 raw write ignored

    // R11: drop the raw lines; pending follows at once, request one edge later
    @(negedge clk);
    src_in   = '0;
    bus_addr = 8'h64;
    #1;
    check(6, bus_rdata, 32'h0);                    // R6 combinational pending
    check(11, {31'b0, irq_fast}, 32'h1);           // R11 old value held
    @(posedge clk);
    @(negedge clk);
    check(11, {31'b0, irq_fast}, 32'h0);           // R11 new value after edge
    rd(11, 8'h44, 32'hFFFFFFFF);                   // R11

    // R1: reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check(1, {30'b0, irq_fast, irq_norm}, 32'h0);  // R1
    rd(1, 8'h04, 32'h1F);                          // R1
    rd(1, 8'h10, 32'h0);                           // R1
    rd(1, 8'h1C, 32'h0);                           // R1
    rd(1, 8'h54, 32'h0);                           // R1
    rd(1, 8'h28, 32'h0);                           // R1
    rd(1, 8'h40, 32'hFFFFFFFF);                    // R1

    // R2 R5: set every source number in turn
    model = '0;
    for (int n = 0; n < 64; n++) begin
      wr(8'h08, 32'(n));
      model[n] = 1'b1;
      if (n < 32) rd(2, 8'h14, model[31:0]);       // R2 low word
      else        rd(5, 8'h10, model[63:32]);      // R5 high word
    end
    // R3: clear them again
    for (int n = 0; n < 64; n++) begin
      wr(8'h0C, 32'(n));
      model[n] = 1'b0;
      if (n < 32) rd(3, 8'h14, model[31:0]);       // R3
      else        rd(3, 8'h10, model[63:32]);      // R3
    end

    // R7: reversed word order, source 19 in word 2, source 63 in word 7
    wr(8'h34, 32'h0000C000);
    wr(8'h08, 32'd19);
    wr(8'h54, 32'h00080000);
    rd(7, 8'h40, 32'h0013000C);                    // R7
    wr(8'h20, 32'h10000000);
    wr(8'h08, 32'd63);
    wr(8'h50, 32'h80000000);
    rd(7, 8'h40, 32'h0013000C);                    // R7 lower priority loses
    wr(8'h20, 32'hF0000000);
    rd(7, 8'h40, 32'h003F000F);                    // R7
    rd(5, 8'h58, 32'h80000000);                    // R5 source 63 at high bit 31

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule